// File: doc/BRIEF.md
# Key-Locked Media Converter Control Registers

This block is the control register bank for a five-port media-interface converter. A plain 32-bit register bus (byte address, write data, write strobe, read strobe, read data) reaches a command register, an identification word, a switch-mode register, one conversion-control register per port, a converter reset-release register and two switch override words. From the stored values the block drives, per port, the interface type (MII pass-through, RMII or RGMII), the line speed, the duplex and the converter enable.

All configuration registers are write-protected. The bank comes out of reset locked and ignores every write to them until a fixed key of four writes has landed on the command register. Once that happens the bank stays open until the next reset. Reads are never blocked. The in-band link, duplex and speed that each RGMII datapath recovers come in on input pins and appear in read-only fields of that port's conversion-control word.

Read data is combinational: `bus_rdata` carries the addressed word in the same cycle as `bus_re` and is zero otherwise. Writes take effect at the rising clock edge on which `bus_we` is high.

Top module: `convctl_regbank`

## Requirements
- R1: The bank unlocks when the command register (offset 0x000) receives writes of 0x000000A5, 0x00000001, 0x0000FFFE and 0x00000001 in that order. Reading offset 0x000 returns 1 in bit 0 once the bank is unlocked and 0 while it is locked.
- R2: A locked command-register write whose value is not the next expected key returns the tracker to its first step, and that write does not count as a first key. Writes to other offsets neither advance nor reset the tracker.
- R3: Once unlocked, the bank stays unlocked until reset, whatever is later written to the command register.
- R4: While locked, writes to offsets 0x020, 0x100 to 0x110, 0x114, 0x304 and 0x308 are dropped, and reads of those offsets still return their stored values.
- R5: Offset 0x020 holds a 5-bit switch mode in bits 4:0 that drives `sw_mode`. Its other bits read as zero.
- R6: Port n's conversion word is at 0x100 + 4*n. Bits 1:0 are the speed code (0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s), bit 2 selects RMII, bit 3 selects RGMII and bit 8 selects full duplex. When bits 2 and 3 are both set, the port runs RGMII.
- R7: When bits 2 and 3 are both clear, the port is in MII pass-through. Its `port_speed` output is then 0, while the stored speed bits still read back unchanged.
- R8: Conversion word bits 12, 13 and 15:14 read the port's in-band link, duplex and speed inputs. Writes to those bits have no effect.
- R9: Bit n of offset 0x114 drives `port_enable[n]`: 1 releases the port's converter and 0 holds it in reset. Bits above the port count read as zero.
- R10: Offsets 0x304 and 0x308 are full 32-bit switch speed and duplex override words, driven on `sw_speed_ovr` and `sw_duplex_ovr`. A value of zero means no override.
- R11: Offset 0x004 reads the `ID_CODE` parameter and ignores writes. Any unmapped offset reads as zero and ignores writes.
- R12: After reset every register is zero, every port is held in reset in MII mode, and the bank is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_re is high |
| inb_link | input | 5 | Per-port in-band link status from the RGMII datapath |
| inb_fdx | input | 5 | Per-port in-band duplex status |
| inb_speed | input | 10 | Per-port in-band speed code, two bits per port |
| unlocked | output | 1 | High once the key sequence has completed |
| sw_mode | output | 5 | Switch-mode field |
| port_rmii | output | 5 | Port runs RMII |
| port_rgmii | output | 5 | Port runs RGMII |
| port_speed | output | 10 | Effective speed code per port, two bits per port, zero in MII pass-through |
| port_full_duplex | output | 5 | Port full duplex |
| port_enable | output | 5 | Converter released from reset |
| sw_speed_ovr | output | 32 | Switch speed override word |
| sw_duplex_ovr | output | 32 | Switch duplex override word |

## Verification
The unlock tracker is exercised with several key patterns. One pattern is interrupted by a write to another offset and must still complete. One breaks at the third step. One repeats the first key, and the repeat must not count as a new start. An attempt that is preceded by a broken start must not succeed. Only the exact, uninterrupted sequence of command writes may open the bank. The conversion words are loaded with one pattern per interface type: RMII, RGMII, both type bits set, and MII with a non-zero speed code. These separate the type priority from the speed gating of the pass-through mode. The in-band status inputs are then raised under a stored word to show that they reach only the read-only fields.

// File: rtl/convctl_regbank.sv
module convctl_regbank #(
  parameter int NPORTS = 5,
  parameter int AW = 12,
  parameter int DW = 32,
  parameter logic [31:0] ID_CODE = 32'h0000_4D43
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  input  logic                  bus_we,
  input  logic                  bus_re,
  output logic [DW-1:0]         bus_rdata,
  input  logic [NPORTS-1:0]     inb_link,
  input  logic [NPORTS-1:0]     inb_fdx,
  input  logic [2*NPORTS-1:0]   inb_speed,
  output logic                  unlocked,
  output logic [4:0]            sw_mode,
  output logic [NPORTS-1:0]     port_rmii,
  output logic [NPORTS-1:0]     port_rgmii,
  output logic [2*NPORTS-1:0]   port_speed,
  output logic [NPORTS-1:0]     port_full_duplex,
  output logic [NPORTS-1:0]     port_enable,
  output logic [DW-1:0]         sw_speed_ovr,
  output logic [DW-1:0]         sw_duplex_ovr
);

  localparam logic [AW-1:0] OFF_CMD   = AW'('h000);
  localparam logic [AW-1:0] OFF_ID    = AW'('h004);
  localparam logic [AW-1:0] OFF_MODE  = AW'('h020);
  localparam logic [AW-1:0] OFF_CONV  = AW'('h100);
  localparam logic [AW-1:0] OFF_CONVE = AW'('h100 + 4*NPORTS);
  localparam logic [AW-1:0] OFF_RST   = AW'('h114);
  localparam logic [AW-1:0] OFF_SWSPD = AW'('h304);
  localparam logic [AW-1:0] OFF_SWDUP = AW'('h308);
  localparam logic [AW-1:0] OFF_HOLE  = AW'('h008);
  localparam int CIW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  localparam logic [DW-1:0] KEY0 = DW'('h0000_00A5);
  localparam logic [DW-1:0] KEY1 = DW'('h0000_0001);
  localparam logic [DW-1:0] KEY2 = DW'('h0000_FFFE);
  localparam logic [DW-1:0] KEY3 = DW'('h0000_0001);

  logic [1:0]              key_step;
  logic                    open_q;
  logic [4:0]              mode_q;
  logic [NPORTS-1:0][3:0]  conv_q;
  logic [NPORTS-1:0]       fdx_q;
  logic [NPORTS-1:0]       rel_q;
  logic [DW-1:0]           swspd_q, swdup_q;

  logic [DW-1:0]  want_key;
  logic           cmd_wr, conv_hit;
  logic [AW-1:0]  conv_off;
  logic [CIW-1:0] conv_idx;

  always_comb begin
    case (key_step)
      2'd0:    want_key = KEY0;
      2'd1:    want_key = KEY1;
      2'd2:    want_key = KEY2;
      default: want_key = KEY3;
    endcase
  end

  assign cmd_wr   = bus_we && (bus_addr == OFF_CMD) && !open_q;
  assign conv_off = bus_addr - OFF_CONV;
  assign conv_idx = conv_off[CIW+1:2];
  assign conv_hit = (bus_addr >= OFF_CONV) && (bus_addr < OFF_CONVE) && (bus_addr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_step <= '0;
      open_q   <= 1'b0;
    end else if (cmd_wr) begin
      if (bus_wdata == want_key) begin
        if (key_step == 2'd3) begin
          open_q   <= 1'b1;
          key_step <= '0;
        end else begin
          key_step <= key_step + 2'd1;
        end
      end else begin
        key_step <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      conv_q  <= '0;
      fdx_q   <= '0;
      rel_q   <= '0;
      swspd_q <= '0;
      swdup_q <= '0;
    end else if (bus_we && open_q) begin
      if (bus_addr == OFF_MODE)  mode_q  <= bus_wdata[4:0];
      if (bus_addr == OFF_RST)   rel_q   <= bus_wdata[NPORTS-1:0];
      if (bus_addr == OFF_SWSPD) swspd_q <= bus_wdata;
      if (bus_addr == OFF_SWDUP) swdup_q <= bus_wdata;
      for (int p = 0; p < NPORTS; p++) begin
        if (conv_hit && (int'(conv_idx) == p)) begin
          conv_q[p] <= bus_wdata[3:0];
          fdx_q[p]  <= bus_wdata[8];
        end
      end
    end
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign port_rgmii[p]       = conv_q[p][3];
    assign port_rmii[p]        = conv_q[p][2] & ~conv_q[p][3];
    assign port_speed[2*p +: 2] = (conv_q[p][3] | conv_q[p][2]) ? conv_q[p][1:0] : 2'b00;
  end

  assign unlocked         = open_q;
  assign sw_mode          = mode_q;
  assign port_full_duplex = fdx_q;
  assign port_enable      = rel_q;
  assign sw_speed_ovr     = swspd_q;
  assign sw_duplex_ovr    = swdup_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == OFF_CMD)   bus_rdata[0] = open_q;
      if (bus_addr == OFF_ID)    bus_rdata = DW'(ID_CODE);
      if (bus_addr == OFF_MODE)  bus_rdata[4:0] = mode_q;
      if (bus_addr == OFF_RST)   bus_rdata[NPORTS-1:0] = rel_q;
      if (bus_addr == OFF_SWSPD) bus_rdata = swspd_q;
      if (bus_addr == OFF_SWDUP) bus_rdata = swdup_q;
      for (int p = 0; p < NPORTS; p++) begin
        if (conv_hit && (int'(conv_idx) == p)) begin
          bus_rdata[3:0]   = conv_q[p];
          bus_rdata[8]     = fdx_q[p];
          bus_rdata[12]    = inb_link[p];
          bus_rdata[13]    = inb_fdx[p];
          bus_rdata[15:14] = inb_speed[2*p +: 2];
        end
      end
    end
  end

  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |=> open_q); // R3

  AST_OPEN_NEEDS_LAST_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(bus_we && bus_addr == OFF_CMD && bus_wdata == KEY3 && key_step == 2'd3)); // R1

  AST_LOCKED_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && bus_we && bus_addr == OFF_MODE) |=> $stable(sw_mode)); // R4

  AST_LOCKED_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> (port_enable == '0)); // R12

  AST_ENABLE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && bus_we && bus_addr == OFF_RST) |=> (port_enable == $past(bus_wdata[NPORTS-1:0]))); // R9

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == OFF_HOLE) |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/convctl_regbank_tb.sv
module convctl_regbank_tb_top;
  localparam logic [31:0] ID = 32'h0000_4D43;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [4:0] inb_link = '0, inb_fdx = '0;
  logic [9:0] inb_speed = '0;
  logic unlocked;
  logic [4:0] sw_mode, port_rmii, port_rgmii, port_full_duplex, port_enable;
  logic [9:0] port_speed;
  logic [31:0] sw_speed_ovr, sw_duplex_ovr;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  convctl_regbank #(.ID_CODE(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .inb_link(inb_link), .inb_fdx(inb_fdx), .inb_speed(inb_speed),
    .unlocked(unlocked), .sw_mode(sw_mode), .port_rmii(port_rmii),
    .port_rgmii(port_rgmii), .port_speed(port_speed),
    .port_full_duplex(port_full_duplex), .port_enable(port_enable),
    .sw_speed_ovr(sw_speed_ovr), .sw_duplex_ovr(sw_duplex_ovr)
  );

  // entry: {req[3:0], op[1:0] (1 write, 2 read-check), addr[11:0], data[31:0], expect[31:0]}
  localparam int NV = 28;
  localparam logic [81:0] VEC [NV] = '{
    {4'd5,  2'd1, 12'h020, 32'hFFFF_FFFF, 32'h0},
    {4'd5,  2'd2, 12'h020, 32'h0, 32'h0000_001F},          // R5
    {4'd6,  2'd1, 12'h100, 32'h0000_0105, 32'h0},
    {4'd6,  2'd2, 12'h100, 32'h0, 32'h0000_0105},          // R6 RMII 100M FD
    {4'd6,  2'd1, 12'h104, 32'h0000_000A, 32'h0},
    {4'd6,  2'd2, 12'h104, 32'h0, 32'h0000_000A},          // R6 RGMII 1000M
    {4'd8,  2'd1, 12'h108, 32'h0000_F002, 32'h0},
    {4'd8,  2'd2, 12'h108, 32'h0, 32'h0000_0002},          // R8 status bits not writable, R7 speed kept
    {4'd6,  2'd1, 12'h10C, 32'h0000_000E, 32'h0},
    {4'd6,  2'd2, 12'h10C, 32'h0, 32'h0000_000E},          // R6 both type bits
    {4'd6,  2'd1, 12'h110, 32'h0000_0104, 32'h0},
    {4'd6,  2'd2, 12'h110, 32'h0, 32'h0000_0104},          // R6 RMII 10M FD
    {4'd9,  2'd1, 12'h114, 32'hFFFF_FFFF, 32'h0},
    {4'd9,  2'd2, 12'h114, 32'h0, 32'h0000_001F},          // R9
    {4'd10, 2'd1, 12'h304, 32'hDEAD_BEEF, 32'h0},
    {4'd10, 2'd2, 12'h304, 32'h0, 32'hDEAD_BEEF},          // R10
    {4'd10, 2'd1, 12'h308, 32'h1234_5678, 32'h0},
    {4'd10, 2'd2, 12'h308, 32'h0, 32'h1234_5678},          // R10
    {4'd11, 2'd1, 12'h004, 32'hFFFF_FFFF, 32'h0},
    {4'd11, 2'd2, 12'h004, 32'h0, ID},                     // R11
    {4'd11, 2'd1, 12'h200, 32'h0000_0055, 32'h0},
    {4'd11, 2'd2, 12'h200, 32'h0, 32'h0},                  // R11
    {4'd11, 2'd2, 12'h102, 32'h0, 32'h0},                  // R11 misaligned
    {4'd3,  2'd1, 12'h000, 32'h0000_0000, 32'h0},
    {4'd3,  2'd2, 12'h000, 32'h0, 32'h0000_0001},          // R3
    {4'd9,  2'd1, 12'h114, 32'h0000_0015, 32'h0},
    {4'd9,  2'd2, 12'h114, 32'h0, 32'h0000_0015},          // R9
    {4'd5,  2'd2, 12'h024, 32'h0, 32'h0}                   // R11 near mode
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    check("R12 unlocked", {31'b0, unlocked}, 32'h0);
    check("R12 outputs", {port_enable, port_rmii, port_rgmii, sw_mode, 12'b0}, 32'h0);
    check("R12 speed", {22'b0, port_speed}, 32'h0);
    rd(12'h000, r); check("R1 locked status", r, 32'h0);
    rd(12'h114, r); check("R12 reset-release", r, 32'h0);

    // R4 writes dropped while locked
    wr(12'h020, 32'h1F);
    rd(12'h020, r); check("R4 mode dropped", r, 32'h0);
    wr(12'h114, 32'h1F);
    check("R4 enable dropped", {27'b0, port_enable}, 32'h0);
    wr(12'h304, 32'hFFFF);
    rd(12'h304, r); check("R4 override dropped", r, 32'h0);

    // R2 break at third step
    wr(12'h000, 32'hA5); wr(12'h000, 32'h1); wr(12'h000, 32'h1234);
    wr(12'h000, 32'h1);
    check("R2 broken sequence", {31'b0, unlocked}, 32'h0);
    // R2 repeated first key does not restart
    wr(12'h000, 32'hA5); wr(12'h000, 32'hA5); wr(12'h000, 32'h1);
    wr(12'h000, 32'hFFFE); wr(12'h000, 32'h1);
    check("R2 repeated key", {31'b0, unlocked}, 32'h0);

    // R1 exact sequence with an interleaved write elsewhere (R2)
    wr(12'h000, 32'hA5);
    wr(12'h020, 32'h3);
    wr(12'h000, 32'h1); wr(12'h000, 32'hFFFE); wr(12'h000, 32'h1);
    check("R1 unlocked", {31'b0, unlocked}, 32'h1);
    rd(12'h000, r); check("R1 status", r, 32'h1);
    rd(12'h020, r); check("R4 interleaved write dropped", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][77:76] == 2'd1) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], r);
        check($sformatf("R%0d vector %0d", VEC[i][81:78], i), r, VEC[i][31:0]);
      end
    end

    check("R5 sw_mode", {27'b0, sw_mode}, 32'h1F);
    check("R6 rmii", {27'b0, port_rmii}, 32'h11);
    check("R6 rgmii", {27'b0, port_rgmii}, 32'h0A);
    check("R7 speed", {22'b0, port_speed}, 32'h089);
    check("R6 duplex", {27'b0, port_full_duplex}, 32'h11);
    check("R9 enable", {27'b0, port_enable}, 32'h15);
    check("R10 outputs", sw_speed_ovr ^ sw_duplex_ovr, 32'hDEAD_BEEF ^ 32'h1234_5678);

    // R8 in-band status on port 2
    inb_link = 5'b00100; inb_fdx = 5'b00100; inb_speed = 10'b00_00_10_00_00;
    rd(12'h108, r); check("R8 inband", r, 32'h0000_B002);
    rd(12'h10C, r); check("R8 other port", r, 32'h0000_000E);

    // R3 / R12 reset relocks
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R12 relocked", {31'b0, unlocked}, 32'h0);
    check("R12 enable cleared", {27'b0, port_enable}, 32'h0);
    wr(12'h020, 32'h7);
    rd(12'h020, r); check("R4 dropped after reset", r, 32'h0);

    finish_run();
  end
endmodule